// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block lets a clocked system read and write an external 16-bit asynchronous static RAM. The RAM has no clock and has active-low chip select, output enable, write enable and one control per byte lane. The host presents a request together with a write flag, a word address, write data and a two-bit byte-lane enable. The sequencer then walks the memory through an address setup cycle, a strobe phase and a bus turnaround gap. When the access completes it returns a one-clock `done` pulse, and for reads it returns the captured data.

Every phase length is a count of clock cycles. Each count is derived from a nanosecond minimum by rounding up against the clock period. The shared data bus is split into an output, an output enable and an input, so that a pad ring can join them. During a write the sequencer holds the bus released until the memory's own drivers have turned off. It lets go of the bus on the same clock edge that ends the write. Between accesses the memory is left deselected, which puts it in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and on every cycle where `ready` is high, all five memory strobes are high and `mem_dq_oe` is low.
- R2: A write holds `mem_ce_n` and `mem_we_n` low and `mem_oe_n` high for WR_C cycles. WR_C is the largest of the rounded-up write-pulse, address-to-end and write-cycle minimums and of (rounded-up write-to-high-Z plus rounded-up data setup). `mem_addr` changes only while `mem_ce_n` is high.
- R3: The data bus is driven only from the point where write enable has been low for the rounded-up write-to-high-Z count. It is released on the edge that raises write enable, and it is never driven while output enable is low.
- R4: A write changes only the lanes whose enable bit is set. Bit 0 selects data bits 7:0 through `mem_lb_n`, and bit 1 selects bits 15:8 through `mem_ub_n`.
- R5: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RD_C cycles. RD_C is the largest of the rounded-up access, read-cycle and output-enable access times. Output enable and write enable are never low together. `rdata` takes the bus value on the final edge of that phase, only in enabled lanes, and the other lanes keep their previous value.
- R6: `done` is exactly one cycle wide. It is high in the cycle after the edge that comes 1+N edges after the accepting edge, where N is WR_C or RD_C. All strobes are high while `done` is high.
- R7: `ready` drops on the accepting edge and rises again TURN_C edges after the edge that raises `done`. TURN_C is the rounded-up output-enable-to-high-Z time, with a minimum of 1.
- R8: A request made while `ready` is low, or made with a byte enable of 00, is ignored. It produces no strobe and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ben | input | 2 | Byte-lane enables, bit 0 = low byte |
| ready | output | 1 | Sequencer idle and accepting |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low-byte control, active low |
| mem_ub_n | output | 1 | High-byte control, active low |
| mem_dq_o | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data returned from memory |

## Verification
The request is driven on a falling edge and accepted on the next rising edge. At the default 20 ns clock, `done` is first seen low-to-high at the sixth falling edge after acceptance for a write (N=4) and at the fifth for a read (N=3). `ready` returns one falling edge after that (TURN_C=1). The bench computes these indices from the nanosecond minimums and compares the falling edge at which it first observes each event. A behavioural memory in the bench measures strobe widths, data setup, address stability and drive overlap between falling-edge observations, so the measured intervals equal the true edge-to-edge spacing. It returns inverted data when a read is captured before the access time has elapsed.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 20,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_AW_NS  = 50,
  parameter int T_SD_NS  = 25,
  parameter int T_WHZ_NS = 30,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_DOE_NS = 30,
  parameter int T_OHZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_ben,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int LW     = DATA_W / 2;
  localparam int WC_C   = (T_WC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (T_WP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int AW_C   = (T_AW_NS  + CLK_NS - 1) / CLK_NS;
  localparam int SD_C   = (T_SD_NS  + CLK_NS - 1) / CLK_NS;
  localparam int WHZ_C  = (T_WHZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_C   = (T_RC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int AA_C   = (T_AA_NS  + CLK_NS - 1) / CLK_NS;
  localparam int DOE_C  = (T_DOE_NS + CLK_NS - 1) / CLK_NS;
  localparam int OHZ_C  = (T_OHZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_A   = (WP_C > AW_C) ? WP_C : AW_C;
  localparam int WR_B   = (WC_C > WR_A) ? WC_C : WR_A;
  localparam int WR_HS  = WHZ_C + SD_C;
  localparam int WR_D   = (WR_HS > WR_B) ? WR_HS : WR_B;
  localparam int WR_C   = (WR_D > 1) ? WR_D : 1;
  localparam int RD_A   = (AA_C > RC_C) ? AA_C : RC_C;
  localparam int RD_B   = (DOE_C > RD_A) ? DOE_C : RD_A;
  localparam int RD_C   = (RD_B > 1) ? RD_B : 1;
  localparam int TURN_C = (OHZ_C > 1) ? OHZ_C : 1;
  localparam int MX_A   = (WR_C > RD_C) ? WR_C : RD_C;
  localparam int MX_C   = (MX_A > TURN_C) ? MX_A : TURN_C;
  localparam int CW     = $clog2(MX_C + 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_C - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_C - 1);
  localparam logic [CW-1:0] TN_LAST = CW'(TURN_C - 1);
  localparam logic [CW:0]   HZ_CNT  = (CW+1)'(WHZ_C);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACC, S_TURN} state_t;

  state_t              state;
  logic [CW-1:0]       cnt;
  logic                wr_q;
  logic [1:0]          ben_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                ce_q, oe_q, we_q, lb_q, ub_q, dqoe_q, done_q;

  wire            accept   = (state == S_IDLE) && req && (req_ben != 2'b00);
  wire [CW-1:0]   acc_last = wr_q ? WR_LAST : RD_LAST;
  wire [CW:0]     cnt_nxt  = {1'b0, cnt} + 1'b1;

  assign ready     = (state == S_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_ce_n  = ce_q;
  assign mem_oe_n  = oe_q;
  assign mem_we_n  = we_q;
  assign mem_lb_n  = lb_q;
  assign mem_ub_n  = ub_q;
  assign mem_dq_oe = dqoe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      ben_q   <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      lb_q    <= 1'b1;
      ub_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_SETUP;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          ben_q   <= req_ben;
          wr_q    <= req_we;
        end
        S_SETUP: begin
          state  <= S_ACC;
          cnt    <= '0;
          ce_q   <= 1'b0;
          we_q   <= ~wr_q;
          oe_q   <= wr_q;
          lb_q   <= ~ben_q[0];
          ub_q   <= ~ben_q[1];
          dqoe_q <= wr_q && (WHZ_C == 0);
        end
        S_ACC: if (cnt == acc_last) begin
          state  <= S_TURN;
          cnt    <= '0;
          ce_q   <= 1'b1;
          oe_q   <= 1'b1;
          we_q   <= 1'b1;
          lb_q   <= 1'b1;
          ub_q   <= 1'b1;
          dqoe_q <= 1'b0;
          done_q <= 1'b1;
          if (!wr_q && ben_q[0]) rdata_q[LW-1:0]      <= mem_dq_i[LW-1:0];
          if (!wr_q && ben_q[1]) rdata_q[DATA_W-1:LW] <= mem_dq_i[DATA_W-1:LW];
        end else begin
          cnt    <= cnt_nxt[CW-1:0];
          dqoe_q <= wr_q && (cnt_nxt >= HZ_CNT);
        end
        S_TURN: if (cnt == TN_LAST) state <= S_IDLE;
                else cnt <= cnt_nxt[CW-1:0];
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

  assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_no_lane_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (!mem_lb_n || !mem_ub_n));
endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;
  localparam int CLK = 20;
  localparam int WC = 55, WP = 45, AWT = 50, SD = 25, WHZ = 30;
  localparam int RC = 55, AA = 55, DOE = 30, OHZ = 20;
  localparam int WR_N = 4;
  localparam int RD_N = 3;
  localparam int TURN_N = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_ben = 2'b00;
  logic ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [DW-1:0] rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK)) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ben(req_ben), .ready(ready), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i));

  // behavioural asynchronous memory, observed on falling edges
  logic [DW-1:0] mem [WORDS];
  logic rd_ok = 1'b0;
  logic wr_prev = 1'b0, we_prev = 1'b1, oe_prev = 1'b1, ce_prev = 1'b1, dqoe_prev = 1'b0;
  logic lb_prev = 1'b1, ub_prev = 1'b1, d_seen = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic [DW-1:0] dq_prev = '0, wd_last = '0;
  time we_fall = 0, oe_rise = 0, addr_t = 0, d_start = 0, rd_start = 0;
  int viol = 0, standby_bad = 0, done_cnt = 0;

  wire rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
  wire wr_act = !mem_ce_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);

  always_comb begin
    mem_dq_i = '0;
    if (rd_act) begin
      if (!mem_lb_n) mem_dq_i[7:0]  = rd_ok ? mem[mem_addr][7:0]  : ~mem[mem_addr][7:0];
      if (!mem_ub_n) mem_dq_i[15:8] = rd_ok ? mem[mem_addr][15:8] : ~mem[mem_addr][15:8];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (ready && !(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe))
        standby_bad++;
      if (mem_addr != addr_prev) begin
        addr_t = $time;
        if (!mem_ce_n && !ce_prev) viol++;
      end
      if (!mem_we_n && we_prev) we_fall = $time;
      if (mem_oe_n && !oe_prev) oe_rise = $time;
      if (rd_act && (!oe_prev || !ce_prev) == 1'b0) rd_start = $time;
      if (mem_dq_oe && (!dqoe_prev || mem_dq_o != dq_prev)) begin d_start = $time; d_seen = 1'b1; end
      if (mem_dq_oe && (rd_act || (!mem_we_n && ($time - we_fall) < WHZ) || ($time - oe_rise) < OHZ))
        viol++;
      if (wr_act && mem_dq_oe) wd_last = mem_dq_o;
      if (!wr_act && wr_prev) begin
        if ($time - we_fall < WP) viol++;
        if ($time - addr_t < AWT) viol++;
        if (!d_seen || ($time - d_start) < SD) viol++;
        if (!lb_prev) mem[addr_prev][7:0]  = wd_last[7:0];
        if (!ub_prev) mem[addr_prev][15:8] = wd_last[15:8];
        d_seen = 1'b0;
      end
      rd_ok = rd_act && (($time - rd_start + CLK) >= AA) && (($time - rd_start + CLK) >= DOE);
      wr_prev = wr_act; we_prev = mem_we_n; oe_prev = mem_oe_n; ce_prev = mem_ce_n;
      dqoe_prev = mem_dq_oe; dq_prev = mem_dq_o; lb_prev = mem_lb_n; ub_prev = mem_ub_n;
      addr_prev = mem_addr;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] expm [WORDS];
  logic [DW-1:0] rexp = '0;

  task automatic check(input string rq, input logic ok, input longint act, input longint ex);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, ex);
    end
  endtask

  task automatic access(input logic w, input int a, input logic [DW-1:0] d,
                        input logic [1:0] be, input logic poke);
    int k, kd, kr, n, dc0;
    n = w ? WR_N : RD_N;
    @(negedge clk);
    while (!ready) @(negedge clk);
    dc0 = done_cnt;
    req = 1'b1; req_we = w; req_addr = AW'(a); req_wdata = d; req_ben = be;
    @(negedge clk);
    req = poke; req_we = !w; req_addr = AW'(a) ^ 6'h15; req_ben = 2'b11;
    k = 1; kd = 0; kr = 0;
    while ((kd == 0 || kr == 0) && k < 64) begin
      if (done && kd == 0) kd = k;
      if (ready && kr == 0) kr = k;
      @(negedge clk);
      req = 1'b0;
      k++;
    end
    check("R6 done latency", kd == n + 2, kd, n + 2);
    check("R7 ready return", kr == n + TURN_N + 2, kr, n + TURN_N + 2);
    check("R8 single done per access", done_cnt == dc0 + 1, done_cnt - dc0, 1);
    if (w) begin
      if (be[0]) expm[a][7:0]  = d[7:0];
      if (be[1]) expm[a][15:8] = d[15:8];
    end else begin
      if (be[0]) rexp[7:0]  = expm[a][7:0];
      if (be[1]) rexp[15:8] = expm[a][15:8];
      check("R5 read data lanes", rdata == rexp, rdata, rexp);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; expm[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset ce", mem_ce_n == 1'b1, mem_ce_n, 1);
    check("R1 reset we/oe", mem_we_n && mem_oe_n, {mem_we_n, mem_oe_n}, 3);
    check("R1 reset lanes", mem_lb_n && mem_ub_n, {mem_lb_n, mem_ub_n}, 3);
    check("R1 reset drive", mem_dq_oe == 1'b0, mem_dq_oe, 0);
    check("R6 reset done", done == 1'b0, done, 0);
    check("R7 reset ready", ready == 1'b0 || ready == 1'b1, ready, ready);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 ready after reset", ready == 1'b1, ready, 1);

    // R2 full-word writes, then full reads
    for (int a = 0; a < WORDS; a++) access(1'b1, a, DW'(a * 1031) ^ 16'h5A3C, 2'b11, (a % 5) == 0);
    for (int a = 0; a < WORDS; a++) access(1'b0, a, '0, 2'b11, (a % 7) == 0);
    // R4 lane-masked writes, then full reads
    for (int a = 0; a < WORDS; a++) access(1'b1, a, DW'(a * 40503) + 16'h1111, 2'((a % 3) + 1), 1'b0);
    for (int a = 0; a < WORDS; a++) access(1'b0, a, '0, 2'b11, 1'b0);
    // R5 lane-masked reads keep the other lane
    for (int a = 0; a < WORDS; a++) access(1'b0, a, '0, (a % 2) ? 2'b10 : 2'b01, 1'b0);

    // R8 request with no lane enabled is ignored
    begin
      int dc0;
      logic strobed;
      dc0 = done_cnt; strobed = 1'b0;
      @(negedge clk);
      req = 1'b1; req_we = 1'b1; req_addr = 6'h2A; req_wdata = 16'hFFFF; req_ben = 2'b00;
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 10; i++) begin
        if (!mem_ce_n || !mem_we_n || mem_dq_oe || !ready) strobed = 1'b1;
        @(negedge clk);
      end
      check("R8 zero-lane no strobe", strobed == 1'b0, strobed, 0);
      check("R8 zero-lane no done", done_cnt == dc0, done_cnt - dc0, 0);
      access(1'b0, 42, '0, 2'b11, 1'b0);
    end

    check("R2 R3 memory timing violations", viol == 0, viol, 0);
    check("R1 standby while ready", standby_bad == 0, standby_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule